// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block runs a single-data-rate SDRAM through its mandatory start-up command script and then signals that a normal memory controller may take over the command bus. It holds the clock-enable low and the chip deselected until the board reports a stable clock. It then times a long stabilization window, raising clock-enable near the end of that window while it issues NOPs. After the window it issues a precharge of all banks, two auto-refresh commands and one mode-register load, with a minimum idle gap after each command. Once the last gap has run out it raises `init_done`.

All delays are given in nanoseconds together with the clock period, and the block converts each one to a whole number of cycles, rounding up. A parameter selects whether the two refreshes come before or after the mode-register load. The mode value is taken from an input and placed on the address lines only during the load command.

The state machine has these states: `S_IDLE` (waiting for clock-stable), `S_STAB_LO` (window, CKE low), `S_STAB_HI` (window tail, CKE high), `S_PRE`, `S_WAIT_RP`, `S_REF_A`, `S_WAIT_RFC_A`, `S_REF_B`, `S_WAIT_RFC_B`, `S_LMR`, `S_WAIT_MRD` and `S_DONE`. Its transitions are as follows:
- IDLE→STAB_LO on clock-stable.
- STAB_LO→STAB_HI and STAB_HI→PRE when the timer expires.
- Each command state moves to its wait state after one cycle.
- WAIT_RP goes to REF_A in the default ordering and to LMR in the alternate ordering.
- WAIT_RFC_A goes to REF_B.
- WAIT_RFC_B goes to LMR in the default ordering and to DONE in the alternate ordering.
- WAIT_MRD goes to DONE in the default ordering and to REF_A in the alternate ordering.
- DONE holds until reset.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `cke`=0, `cs_n`=1 and `init_done`=0. A reset at any point restarts the whole script.
- R2: Until the first clock edge at which `clk_stable` is sampled high outside reset, the block drives command inhibit (`cs_n`=1) with `cke`=0. The stabilization window starts on the cycle after that edge.
- R3: The window lasts STAB = ceil(T_STAB_NS*1000/CLK_PERIOD_PS) cycles. The first STAB−CKE_TAIL_CYC cycles drive `cke`=0 with command inhibit. The last CKE_TAIL_CYC cycles drive `cke`=1 with NOP. After that, `cke` stays 1 until reset.
- R4: {`cs_n`,`ras_n`,`cas_n`,`we_n`} encodes the commands as follows:
  - NOP is 0111.
  - PRECHARGE is 0010, with `addr[10]`=1 and all other address bits 0.
  - AUTO REFRESH is 0001.
  - LOAD MODE is 0000, with `ba`=0 and `addr`=`mode_word`.
  - Command inhibit is 1111.
  - Outside PRECHARGE and LOAD MODE, `addr` and `ba` are 0.
- R5: PRECHARGE is driven on the cycle right after the window ends. Every command lasts exactly one cycle.
- R6: The next command after PRECHARGE follows max(ceil(T_RP_NS*1000/CLK_PERIOD_PS),2) cycles later, with NOP in between.
- R7: Each AUTO REFRESH is followed by NOPs, and the next event comes max(ceil(T_RFC_NS*1000/CLK_PERIOD_PS),2) cycles after it.
- R8: LOAD MODE is followed by NOPs, and the next event comes max(T_MRD_CYC,2) cycles after it.
- R9: With REF_AFTER_LMR=0 the order is PRECHARGE, REFRESH, REFRESH, LOAD MODE. With REF_AFTER_LMR=1 the order is PRECHARGE, LOAD MODE, REFRESH, REFRESH.
- R10: `init_done` rises exactly one gap after the last command, with NOP and `cke`=1 on the bus. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable | input | 1 | Clock is within its timing limits |
| mode_word | input | ADDR_W | Mode register value driven during LOAD MODE |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines |
| init_done | output | 1 | Script finished; controller may take over |

## Verification
A wrong state or a wrong timer load shows on the command pins in the first cycle it takes effect. The symptom is a command one cycle early or late, a NOP where a command belongs, or `cke` changing at the wrong point in the window. The bench therefore compares every pin on every cycle against a script that it builds itself, so any such slip is reported in the cycle it happens. Both orderings run side by side, and a mid-window reset checks that the timers restart from the start.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE, S_STAB_LO, S_STAB_HI, S_PRE, S_WAIT_RP,
        S_REF_A, S_WAIT_RFC_A, S_REF_B, S_WAIT_RFC_B,
        S_LMR, S_WAIT_MRD, S_DONE
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_cmd_enc.sv
module sdram_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  sdram_cmd_e        cmd,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int ALL_BANK_BIT = 10;

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    always_comb begin
        addr = '0;
        ba   = '0;
        if (cmd == CMD_PRE)
            addr[ALL_BANK_BIT] = 1'b1;
        else if (cmd == CMD_LMR)
            addr = mode_word;
    end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W        = 12,
    parameter int BA_W          = 2,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int T_STAB_NS     = 100000,
    parameter int CKE_TAIL_CYC  = 8,
    parameter int T_RP_NS       = 20,
    parameter int T_RFC_NS      = 66,
    parameter int T_MRD_CYC     = 2,
    parameter bit REF_AFTER_LMR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_stable,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int STAB_CYC = ceil_div(T_STAB_NS * 1000, CLK_PERIOD_PS);
    localparam int HI_W     = max2(CKE_TAIL_CYC, 1);
    localparam int LO_W     = max2(STAB_CYC - HI_W, 1);
    localparam int RP_W     = max2(ceil_div(T_RP_NS * 1000, CLK_PERIOD_PS) - 1, 1);
    localparam int RFC_W    = max2(ceil_div(T_RFC_NS * 1000, CLK_PERIOD_PS) - 1, 1);
    localparam int MRD_W    = max2(T_MRD_CYC - 1, 1);
    localparam int MAX_W    = max2(max2(LO_W, HI_W), max2(max2(RP_W, RFC_W), MRD_W));
    localparam int CNT_W    = $clog2(MAX_W + 1);

    seq_state_e       st, nxt;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expired;
    sdram_cmd_e       cmd;

    sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    // Next state and timer load
    always_comb begin
        nxt    = st;
        ld     = 1'b0;
        ld_val = '0;
        unique case (st)
            S_IDLE: if (clk_stable) begin
                nxt = S_STAB_LO; ld = 1'b1; ld_val = CNT_W'(LO_W - 1);
            end
            S_STAB_LO: if (expired) begin
                nxt = S_STAB_HI; ld = 1'b1; ld_val = CNT_W'(HI_W - 1);
            end
            S_STAB_HI: if (expired) nxt = S_PRE;
            S_PRE: begin
                nxt = S_WAIT_RP; ld = 1'b1; ld_val = CNT_W'(RP_W - 1);
            end
            S_WAIT_RP: if (expired) nxt = REF_AFTER_LMR ? S_LMR : S_REF_A;
            S_REF_A: begin
                nxt = S_WAIT_RFC_A; ld = 1'b1; ld_val = CNT_W'(RFC_W - 1);
            end
            S_WAIT_RFC_A: if (expired) nxt = S_REF_B;
            S_REF_B: begin
                nxt = S_WAIT_RFC_B; ld = 1'b1; ld_val = CNT_W'(RFC_W - 1);
            end
            S_WAIT_RFC_B: if (expired) nxt = REF_AFTER_LMR ? S_DONE : S_LMR;
            S_LMR: begin
                nxt = S_WAIT_MRD; ld = 1'b1; ld_val = CNT_W'(MRD_W - 1);
            end
            S_WAIT_MRD: if (expired) nxt = REF_AFTER_LMR ? S_REF_A : S_DONE;
            S_DONE: nxt = S_DONE;
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cke       = 1'b1;
        cmd       = CMD_NOP;
        init_done = 1'b0;
        unique case (st)
            S_IDLE, S_STAB_LO: begin cke = 1'b0; cmd = CMD_INH; end
            S_PRE:             cmd = CMD_PRE;
            S_REF_A, S_REF_B:  cmd = CMD_REF;
            S_LMR:             cmd = CMD_LMR;
            S_DONE:            init_done = 1'b1;
            default:           cmd = CMD_NOP;
        endcase
    end

    sdram_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .cmd       (cmd),
        .mode_word (mode_word),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr)
    );

    logic bus_active;
    assign bus_active = !cs_n && !(ras_n && cas_n && we_n);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!cke && cs_n && !init_done));

    // R3
    cke_no_fall_chk: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    // R3
    cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (rst)
        bus_active |-> cke);

    // R5
    one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        bus_active |=> (!cs_n && ras_n && cas_n && we_n));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R10
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (cke && !bus_active && !cs_n));
endmodule

// File: tb/sdram_pwrup_seq_test.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_test;
    localparam int PER_PS  = 8000;
    localparam int STAB_NS = 2000;
    localparam int TAIL    = 8;
    localparam int RP_NS   = 20;
    localparam int RFC_NS  = 66;
    localparam int MRD_CYC = 2;

    typedef struct packed {
        logic       cke;
        logic [3:0] cmd;
        logic       done;
        logic [7:0] req;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_stable = 1'b0;
    logic [11:0] mode_word = 12'h033;

    logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic [1:0]  ba_a;
    logic [11:0] addr_a;
    logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [1:0]  ba_b;
    logic [11:0] addr_b;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sdram_pwrup_seq #(.CLK_PERIOD_PS(PER_PS), .T_STAB_NS(STAB_NS), .CKE_TAIL_CYC(TAIL),
        .T_RP_NS(RP_NS), .T_RFC_NS(RFC_NS), .T_MRD_CYC(MRD_CYC), .REF_AFTER_LMR(1'b0)) uut (
        .clk(clk), .rst(rst), .clk_stable(clk_stable), .mode_word(mode_word),
        .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a),
        .ba(ba_a), .addr(addr_a), .init_done(done_a));

    sdram_pwrup_seq #(.CLK_PERIOD_PS(PER_PS), .T_STAB_NS(STAB_NS), .CKE_TAIL_CYC(TAIL),
        .T_RP_NS(RP_NS), .T_RFC_NS(RFC_NS), .T_MRD_CYC(MRD_CYC), .REF_AFTER_LMR(1'b1)) uut_alt (
        .clk(clk), .rst(rst), .clk_stable(clk_stable), .mode_word(mode_word),
        .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b),
        .ba(ba_b), .addr(addr_b), .init_done(done_b));

    function automatic int cdiv(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    function automatic int gap(input int n);
        return (n < 2) ? 2 : n;
    endfunction

    // One command, then NOPs up to the gap
    task automatic push_cmd(ref ent_t q[$], input logic [3:0] c, input int g, input int r);
        q.push_back({1'b1, c, 1'b0, 8'(r)});
        for (int i = 1; i < g; i++) q.push_back({1'b1, 4'b0111, 1'b0, 8'(r)});
    endtask

    task automatic build(ref ent_t q[$], input bit alt);
        int stab;
        stab = cdiv(STAB_NS * 1000, PER_PS);
        q.delete();
        for (int i = 0; i < stab - TAIL; i++) q.push_back({1'b0, 4'b1111, 1'b0, 8'd3}); // R3
        for (int i = 0; i < TAIL; i++)        q.push_back({1'b1, 4'b0111, 1'b0, 8'd3});
        push_cmd(q, 4'b0010, gap(cdiv(RP_NS * 1000, PER_PS)), 6);   // R5, R6
        if (alt) begin                                              // R9
            push_cmd(q, 4'b0000, gap(MRD_CYC), 9);
            push_cmd(q, 4'b0001, gap(cdiv(RFC_NS * 1000, PER_PS)), 9);
            push_cmd(q, 4'b0001, gap(cdiv(RFC_NS * 1000, PER_PS)), 9);
        end else begin                                              // R7, R8
            push_cmd(q, 4'b0001, gap(cdiv(RFC_NS * 1000, PER_PS)), 7);
            push_cmd(q, 4'b0001, gap(cdiv(RFC_NS * 1000, PER_PS)), 7);
            push_cmd(q, 4'b0000, gap(MRD_CYC), 8);
        end
        q.push_back({1'b1, 4'b0111, 1'b1, 8'd10});                 // R10
    endtask

    ent_t qa[$];
    ent_t qb[$];
    bit   started  = 1'b0;
    bit   last_rst = 1'b1;
    bit   edge_seen = 1'b0;

    // Reference model, advanced on each edge
    always @(posedge clk) begin
        edge_seen = 1'b1;
        last_rst  = rst;
        if (rst) begin
            started = 1'b0;
        end else if (!started && clk_stable) begin                 // R2
            started = 1'b1;
            build(qa, 1'b0);
            build(qb, 1'b1);
        end else if (started) begin
            if (qa.size() > 1) void'(qa.pop_front());
            if (qb.size() > 1) void'(qb.pop_front());
        end
    end

    task automatic check(input string nm, input ent_t e, input logic ck, input logic [3:0] c,
                         input logic dn, input logic [11:0] ad, input logic [1:0] b);
        logic [11:0] ea;
        ea = (e.cmd == 4'b0010) ? 12'h400 : (e.cmd == 4'b0000) ? mode_word : 12'h000;
        checks++;
        if (ck !== e.cke || c !== e.cmd || dn !== e.done) begin
            fails++;
            $display("FAIL %s R%0d: cke/cmd/done = %b/%b/%b expected %b/%b/%b at %0t",
                     nm, e.req, ck, c, dn, e.cke, e.cmd, e.done, $time);
        end
        checks++;
        if (ad !== ea || b !== 2'b00) begin                        // R4
            fails++;
            $display("FAIL %s R4: addr/ba = %h/%b expected %h/00 at %0t", nm, ad, b, ea, $time);
        end
    endtask

    always @(negedge clk) begin
        ent_t ia;
        ent_t ib;
        if (edge_seen) begin
            // R1 in reset, R2 while waiting for a stable clock
            ia = {1'b0, 4'b1111, 1'b0, (last_rst ? 8'd1 : 8'd2)};
            ib = ia;
            if (started) begin ia = qa[0]; ib = qb[0]; end
            check("uut", ia, cke_a, {cs_a, ras_a, cas_a, we_a}, done_a, addr_a, ba_a);
            check("uut_alt", ib, cke_b, {cs_b, ras_b, cas_b, we_b}, done_b, addr_b, ba_b);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 5000);
        fails++;
        $display("FAIL watchdog R10: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);         // R2: clock not yet stable
        clk_stable = 1'b1;
        repeat (100) @(negedge clk);        // inside the window
        rst = 1'b1;                         // R1: restart mid-window
        clk_stable = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        clk_stable = 1'b1;
        repeat (350) @(negedge clk);        // full script, both orderings
        rst = 1'b1;
        mode_word = 12'h227;                // R4: other mode value
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (350) @(negedge clk);        // clk_stable held high
        finish_run();
    end
endmodule